// File: doc/BRIEF.md
# Bidirectional Selectable-Length Scan Shift Register

This block is the serial core of a row-scan driver. A chain of stages (65 by default) accepts one bit per rising clock edge and presents every stage in parallel to a downstream latch. Two serial ports, A and B, swap roles under a direction input. In forward mode port A feeds stage 1 and port B carries the cascade output. In reverse mode port B feeds the last stage and port A carries the cascade output. Each bidirectional port is modelled as separate input, output and output-enable signals.

A length input selects whether all stages or one fewer are active. This sets how many shifts a bit needs to reach the cascade output, so several devices can be chained to any row count. In short mode the idle position depends on direction. Forward short mode drops the last stage. Reverse short mode drops the first stage. A one-hot flag vector tells the output stage which power output must be held in high impedance.

The direction and length inputs are sampled on each rising edge. A change between edges leaves the stored bits alone and takes effect at the next edge.

Top module: `scan_shift_chain`

## Requirements
- R1: A synchronous active-high reset clears every stage to 0. While the stages are 0, both serial outputs read 0.
- R2: With `dir_fwd`=1 at a rising edge, stage 1 (bit 0 of `stage_q`) takes `a_in` and each stage k>1 takes the old stage k-1. `b_in` has no effect on the stages.
- R3: With `dir_fwd`=0 at a rising edge, the last stage (bit NUM_STAGES-1) takes `b_in` and each stage k takes the old stage k+1. `a_in` has no effect on the stages.
- R4: Changing `dir_fwd` or `len_full` between rising edges leaves `stage_q` unchanged until the next edge.
- R5: In full-length mode (`len_full`=1) the first bit entered appears on the active serial output after exactly NUM_STAGES shifts. In forward mode this is `b_out` = last stage. In reverse mode this is `a_out` = stage 1.
- R6: In forward short mode (`len_full`=0, `dir_fwd`=1), `b_out` presents stage NUM_STAGES-1, so a bit arrives there after exactly NUM_STAGES-1 shifts. `drop_hiz` has only bit NUM_STAGES-1 set.
- R7: In reverse short mode (`len_full`=0, `dir_fwd`=0), `a_out` presents stage 2 (bit 1), so a bit arrives there after exactly NUM_STAGES-1 shifts. `drop_hiz` has only bit 0 set.
- R8: `b_oe`=1 and `a_oe`=0 when the last sampled direction is forward, and the reverse otherwise. The inactive output reads 0. `drop_hiz` is all zero in full mode. These outputs follow the `dir_fwd` and `len_full` values sampled at the most recent rising edge.
- R9: A new bit is accepted on every consecutive edge with no idle cycles. A continuous stream appears unaltered on the cascade output, delayed by the selected length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| dir_fwd | input | 1 | 1 = forward (A in, B out), 0 = reverse (B in, A out) |
| len_full | input | 1 | 1 = all NUM_STAGES stages active, 0 = NUM_STAGES-1 |
| a_in | input | 1 | Port A input buffer |
| a_out | output | 1 | Port A output driver value |
| a_oe | output | 1 | Port A output enable |
| b_in | input | 1 | Port B input buffer |
| b_out | output | 1 | Port B output driver value |
| b_oe | output | 1 | Port B output enable |
| stage_q | output | NUM_STAGES | Parallel stage contents, bit 0 = stage 1 |
| drop_hiz | output | NUM_STAGES | One-hot flag of the power output forced to high impedance |

## Verification
The bench targets the exact cascade delay in each of the four direction and length modes. A tap placed one stage off would deliver the marker bit a shift early or late. Reverse short mode is checked separately, because a design that dropped the wrong end would output stage 1 and flag the wrong output. A configuration change is applied in the middle of a cycle to catch designs that switch the enables or the stored bits before the edge. Random data is driven on the inactive port, so a design that listens to the wrong input corrupts the stage bus and fails the check against the reference model.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Sampled shift configuration.
  typedef struct packed {
    logic fwd;   // 1 = forward shifting
    logic full;  // 1 = all stages active
  } scan_cfg_t;

  localparam scan_cfg_t SCAN_CFG_DEFAULT = '{fwd: 1'b1, full: 1'b1};

endpackage

// File: rtl/scan_cfg_reg.sv
module scan_cfg_reg
  import scan_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      dir_fwd,
  input  logic      len_full,
  output scan_cfg_t cfg
);

  // The configuration is captured on every edge, reset included, so the
  // enables match the pins as soon as reset is released.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.fwd  <= dir_fwd;
      cfg.full <= len_full;
    end else begin
      cfg.fwd  <= dir_fwd;
      cfg.full <= len_full;
    end
  end

endmodule

// File: rtl/scan_stage_array.sv
module scan_stage_array #(
  parameter int NUM_STAGES = 65
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_fwd,
  input  logic                  a_in,
  input  logic                  b_in,
  output logic [NUM_STAGES-1:0] q
);

  localparam int LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] nxt;

  // Each stage picks its lower or upper neighbour. The end stages pick a port.
  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    logic from_lo;
    logic from_hi;
    if (i == 0) begin : g_lo_port
      assign from_lo = a_in;
    end else begin : g_lo_stage
      assign from_lo = q[i-1];
    end
    if (i == LAST) begin : g_hi_port
      assign from_hi = b_in;
    end else begin : g_hi_stage
      assign from_hi = q[i+1];
    end
    assign nxt[i] = shift_fwd ? from_lo : from_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R1: reset leaves every stage at 0
  p_reset_clear_r1: assert property (@(posedge clk) $past(rst) |-> (q == '0));

  // R2: forward entry from port A and upward movement
  p_fwd_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(shift_fwd)) |->
      (q[0] == $past(a_in)) && (q[LAST:1] == $past(q[LAST-1:0])));

  // R3: reverse entry from port B and downward movement
  p_rev_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(shift_fwd)) |->
      (q[LAST] == $past(b_in)) && (q[LAST-1:0] == $past(q[LAST:1])));

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_pkg::*;
#(
  parameter int NUM_STAGES = 65
) (
  input  logic                  clk,
  input  logic                  rst,
  input  scan_cfg_t             cfg,
  input  logic [NUM_STAGES-1:0] q,
  output logic                  a_out,
  output logic                  a_oe,
  output logic                  b_out,
  output logic                  b_oe,
  output logic [NUM_STAGES-1:0] drop_hiz
);

  localparam int LAST     = NUM_STAGES - 1;
  localparam int FWD_TAP  = LAST - 1;   // forward short mode output stage
  localparam int REV_TAP  = 1;          // reverse short mode output stage

  logic fwd_tap_bit;
  logic rev_tap_bit;

  always_comb begin
    fwd_tap_bit = cfg.full ? q[LAST] : q[FWD_TAP];
    rev_tap_bit = cfg.full ? q[0]    : q[REV_TAP];
    b_oe  = cfg.fwd;
    a_oe  = ~cfg.fwd;
    b_out = cfg.fwd  ? fwd_tap_bit : 1'b0;
    a_out = ~cfg.fwd ? rev_tap_bit : 1'b0;
    drop_hiz = '0;
    if (!cfg.full) begin
      if (cfg.fwd) drop_hiz[LAST] = 1'b1;
      else         drop_hiz[0]    = 1'b1;
    end
  end

  // R6: at most one output dropped at any time
  p_drop_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drop_hiz));

  // R8: a disabled port never drives a one
  p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
    (!a_oe |-> !a_out) and (!b_oe |-> !b_out));

endmodule

// File: rtl/scan_shift_chain.sv
module scan_shift_chain
  import scan_pkg::*;
#(
  parameter int NUM_STAGES = 65
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dir_fwd,
  input  logic                  len_full,
  input  logic                  a_in,
  output logic                  a_out,
  output logic                  a_oe,
  input  logic                  b_in,
  output logic                  b_out,
  output logic                  b_oe,
  output logic [NUM_STAGES-1:0] stage_q,
  output logic [NUM_STAGES-1:0] drop_hiz
);

  scan_cfg_t cfg;

  scan_cfg_reg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .dir_fwd  (dir_fwd),
    .len_full (len_full),
    .cfg      (cfg)
  );

  scan_stage_array #(.NUM_STAGES(NUM_STAGES)) u_stages (
    .clk       (clk),
    .rst       (rst),
    .shift_fwd (dir_fwd),
    .a_in      (a_in),
    .b_in      (b_in),
    .q         (stage_q)
  );

  scan_port_ctrl #(.NUM_STAGES(NUM_STAGES)) u_ports (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg),
    .q        (stage_q),
    .a_out    (a_out),
    .a_oe     (a_oe),
    .b_out    (b_out),
    .b_oe     (b_oe),
    .drop_hiz (drop_hiz)
  );

  // R8: enables reflect the direction sampled at the last edge
  p_cfg_at_edge_r8: assert property (@(posedge clk) disable iff (rst)
    (b_oe == $past(dir_fwd)) && (a_oe == !$past(dir_fwd)));

endmodule

// File: tb/sim_scan_shift_chain.sv
module sim_scan_shift_chain;

  localparam int N = 65;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_fwd = 1'b1;
  logic len_full = 1'b1;
  logic a_in = 1'b0;
  logic b_in = 1'b0;
  logic a_out, a_oe, b_out, b_oe;
  logic [N-1:0] stage_q, drop_hiz;

  int checks = 0;
  int fails  = 0;

  logic   sb[$];          // expected cascade bits, oldest first
  logic [N-1:0] exp_q;    // bench model of the stage bus

  always #4 clk = ~clk;   // 125 MHz

  scan_shift_chain #(.NUM_STAGES(N)) u0 (
    .clk(clk), .rst(rst), .dir_fwd(dir_fwd), .len_full(len_full),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .stage_q(stage_q), .drop_hiz(drop_hiz)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One rising edge with the given port inputs, sampled 2 ns later.
  task automatic shift1(input logic ain, input logic bin);
    a_in = ain;
    b_in = bin;
    @(posedge clk);
    #2;
    if (dir_fwd) exp_q = {exp_q[N-2:0], ain};
    else         exp_q = {bin, exp_q[N-1:1]};
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    #2;
    rst = 1'b0;
    exp_q = '0;
    sb.delete();
  endtask

  // Marker bit after reset: absent after L-1 shifts, present after L.
  task automatic latency(input logic fwd, input logic full, input string req);
    int len;
    logic outp;
    len = full ? N : N - 1;
    dir_fwd = fwd;
    len_full = full;
    do_reset();
    for (int k = 1; k <= len; k++) begin
      if (fwd) shift1(k == 1, 1'b0);
      else     shift1(1'b0, k == 1);
      outp = fwd ? b_out : a_out;
      if (k == len - 1) chk({req, " marker early"}, N'(outp), N'(0));
      if (k == len)     chk({req, " marker on time"}, N'(outp), N'(1));
    end
  endtask

  // Scoreboard stream: driver pushes each entered bit, and the output is
  // compared to the oldest entry once L bits are in flight.
  task automatic stream(input logic fwd, input logic full, input int nbits, input string req);
    int len;
    logic bit_v, junk, outp;
    len = full ? N : N - 1;
    dir_fwd = fwd;
    len_full = full;
    sb.delete();
    for (int i = 0; i < nbits; i++) begin
      bit_v = 1'($urandom);
      junk  = 1'($urandom);
      if (fwd) shift1(bit_v, junk);
      else     shift1(junk, bit_v);
      sb.push_back(bit_v);
      if (sb.size() == len) begin
        outp = fwd ? b_out : a_out;
        chk({req, " cascade R9"}, N'(outp), N'(sb.pop_front()));
      end
    end
    chk({req, " stage bus"}, stage_q, exp_q);
    chk("R8 enables", N'({a_oe, b_oe}), N'({!fwd, fwd}));
    chk("R8 idle output low", N'(fwd ? a_out : b_out), N'(0));
  endtask

  initial begin
    logic [N-1:0] snap;
    exp_q = '0;
    do_reset();
    // R1: reset state
    chk("R1 stages cleared", stage_q, '0);
    chk("R1 serial outputs low", N'({a_out, b_out}), N'(0));
    chk("R8 no drop in full mode", drop_hiz, '0);

    latency(1'b1, 1'b1, "R5 fwd full");
    latency(1'b0, 1'b1, "R5 rev full");
    latency(1'b1, 1'b0, "R6 fwd short");
    chk("R6 drop flag last", drop_hiz, N'(1) << (N - 1));
    latency(1'b0, 1'b0, "R7 rev short");
    chk("R7 drop flag first", drop_hiz, N'(1));

    stream(1'b1, 1'b1, 300, "R2 fwd full");
    stream(1'b0, 1'b1, 300, "R3 rev full");
    stream(1'b1, 1'b0, 300, "R6 fwd short");
    stream(1'b0, 1'b0, 300, "R7 rev short");

    // R4 / R8: change configuration mid-cycle
    stream(1'b1, 1'b1, 100, "R2 preload");
    snap = stage_q;
    dir_fwd = 1'b0;
    len_full = 1'b0;
    #1;
    chk("R4 stages held after mid-cycle change", stage_q, snap);
    chk("R8 enables unchanged before edge", N'({a_oe, b_oe}), N'(2'b01));
    chk("R8 drop flag unchanged before edge", drop_hiz, '0);
    shift1(1'b1, 1'b1);
    chk("R3 first reverse shift", stage_q, {1'b1, snap[N-1:1]});
    chk("R8 enables after edge", N'({a_oe, b_oe}), N'(2'b10));
    chk("R7 drop flag after edge", drop_hiz, N'(1));

    // R1: reset in the middle of traffic
    rst = 1'b1;
    @(posedge clk);
    #2;
    chk("R1 mid-stream reset", stage_q, '0);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule